// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Port

This block is an 8-bit SPI engine that can run as the clock master or as a selected slave. A small register window holds a control byte and a data byte. When the block is master, writing the data byte starts a transfer. When the block is slave, writing the data byte loads the byte sent back in the next frame. The received byte is read back through the same data address. Two sticky flags leave the block as plain outputs: one for a completed transfer and one for a mode fault.

Each serial pin appears as an input, an output value and an output enable, so a pad ring can wrap them. The slave-select pin has four roles in master mode. Its role is chosen by an external direction bit together with the output-enable bit of the control byte. One of these roles watches for another master pulling the line low, and the block then steps down out of master mode. A one-wire option moves all traffic onto a single data pin, with a control bit setting its direction. A stop-in-wait option freezes the master clock generator while the chip-level wait input is high.

Top module: `spi_port_ctl`

## Requirements
- R1: After reset the control byte (address 0) and the received byte (address 1) read 0. Both flags are low, and no pin output enable is asserted while the slave-select pad is high.
- R2: In master mode a data write with the engine idle runs 8 SCK pulses. SCK idles low, input is sampled on the rising edge and output changes on the falling edge, and each half period lasts HALF_CYC clocks. The done flag is set 16*HALF_CYC clocks after the write edge and is cleared by the next accepted data write.
- R3: Control bit 2 picks the shift order: 0 sends bit 7 first, 1 sends bit 0 first. In both orders the written and received bytes keep their most significant bit in bit 7.
- R4: In master mode the external direction bit D and control bit 1 (E) set the slave-select role, and the flags ss_oe_o and ss_gp_o show it. D=0,E=0 is a fault-watching input. D=0,E=1 is a general-purpose input (ss_gp_o=1). D=1,E=0 is a general-purpose output (ss_gp_o=1). D=1,E=1 is an automatic select output (ss_oe_o=1). Only the fault-watching role reacts to a low pad.
- R5: In slave mode (control bit 0 = 0) slave-select is always an input, whatever D and E are. ss_oe_o and ss_gp_o stay 0, and a low pad never raises the mode-fault flag.
- R6: In the fault-watching role, a low slave-select pad sets the mode-fault flag and clears the master bit. This drops the SCK and MOSI output enables. A control write clears the flag.
- R7: The automatic select output goes low on the write edge, one half period before the first SCK edge. It returns high on the same edge that sets the done flag.
- R8: With control bit 3 set and wait_i high, the master half-period counter and SCK freeze, so the transfer stretches by exactly the number of waited clocks. With bit 3 clear, wait_i has no effect.
- R9: With control bit 4 set in master mode, the MOSI pin carries both directions and input is taken from it. Control bit 5 drives MOSI when 1 and releases it when 0.
- R10: With control bit 4 set in slave mode, the MISO pin carries both directions and input is taken from it. Control bit 5 selects whether it is driven.
- R11: In slave mode with select low, the byte loaded by a data write goes out on MISO while the byte on MOSI is received. Done is set after the eighth falling SCK edge.
- R12: A data write while a master transfer is running is ignored: the outgoing bits, the timing and the result do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control byte, 1 = data byte |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| ss_dir_i | input | 1 | Direction bit of the slave-select pin from the port logic |
| wait_i | input | 1 | Chip wait-mode request |
| sck_i | input | 1 | SCK pad input |
| sck_o | output | 1 | SCK output value |
| sck_oe_o | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pad input |
| mosi_o | output | 1 | MOSI output value |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pad input |
| miso_o | output | 1 | MISO output value |
| miso_oe_o | output | 1 | MISO output enable |
| ss_i | input | 1 | Slave-select pad input |
| ss_o | output | 1 | Automatic slave-select output value |
| ss_oe_o | output | 1 | Slave-select output enable (automatic role) |
| ss_gp_o | output | 1 | Pin handed to general-purpose port logic |
| xfer_done_o | output | 1 | Sticky transfer-complete flag |
| mode_fault_o | output | 1 | Sticky mode-fault flag |

## Verification
The hardest situation to reach is a wait request that arrives part way through a master frame with stop-in-wait enabled. The frame must stretch by exactly the waited clocks while the captured bits stay intact. The bench raises wait_i at a fixed clock inside the frame for a known length and predicts the done edge from that length. It also repeats the same window with stop-in-wait cleared. A second hard case is a data write that lands mid-frame. The bench drives that write from inside the frame loop, so the write arrives while SCK is toggling.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    // Control byte, bit 0 is the master bit.
    typedef struct packed {
        logic bidir_drive;
        logic one_wire;
        logic stop_wait;
        logic lsb_first;
        logic ss_out_en;
        logic master;
    } spi_ctrl_t;

    localparam int CTRL_W = $bits(spi_ctrl_t);

    typedef enum logic [2:0] {
        SS_SLAVE_IN,
        SS_FAULT_IN,
        SS_GP_IN,
        SS_GP_OUT,
        SS_AUTO_OUT
    } ss_func_e;

    function automatic ss_func_e ss_decode(input logic master, input logic dir, input logic oe);
        if (!master) return SS_SLAVE_IN;
        case ({dir, oe})
            2'b00:   return SS_FAULT_IN;
            2'b01:   return SS_GP_IN;
            2'b10:   return SS_GP_OUT;
            default: return SS_AUTO_OUT;
        endcase
    endfunction

endpackage

// File: rtl/spi_sync2.sv
module spi_sync2 #(
    parameter int W = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            s1_q <= d;
            q    <= s1_q;
        end
    end
endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
    import spi_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctrl_we,
    input  spi_ctrl_t ctrl_wdata,
    input  logic      fault_req,
    output spi_ctrl_t ctrl_q,
    output logic      fault_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            fault_q <= 1'b0;
        end else if (fault_req) begin
            ctrl_q.master <= 1'b0;
            fault_q       <= 1'b1;
        end else if (ctrl_we) begin
            ctrl_q  <= ctrl_wdata;
            fault_q <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_ss_sel.sv
module spi_ss_sel
    import spi_port_pkg::*;
(
    input  logic master,
    input  logic ss_out_en,
    input  logic ss_dir,
    input  logic ss_s,
    input  logic m_busy,
    output logic fault_req,
    output logic ss_o,
    output logic ss_oe,
    output logic ss_gp
);
    ss_func_e func;

    always_comb begin
        func      = ss_decode(master, ss_dir, ss_out_en);
        ss_oe     = (func == SS_AUTO_OUT);
        ss_gp     = (func == SS_GP_IN) || (func == SS_GP_OUT);
        fault_req = (func == SS_FAULT_IN) && !ss_s;
        ss_o      = !m_busy;
    end
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng #(
    parameter int DATA_W   = 8,
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_master,
    input  logic              lsb_first,
    input  logic              clk_run,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sck_s,
    input  logic              ss_s,
    input  logic              din_s,
    output logic              busy_o,
    output logic              sck_o,
    output logic              tx_bit_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              done_o
);
    localparam int NEDGE = 2 * DATA_W;
    localparam int EW    = $clog2(NEDGE);
    localparam int BW    = $clog2(DATA_W);
    localparam int HW    = $clog2(HALF_CYC + 1);

    logic [DATA_W-1:0] sh_q;
    logic              rbit_q;
    logic [HW-1:0]     hc_q;
    logic [EW-1:0]     ec_q;
    logic [BW-1:0]     sc_q;
    logic              s_run_q;
    logic              sck_d_q;

    function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] v,
                                                   input logic b, input logic lsb);
        return lsb ? {b, v[DATA_W-1:1]} : {v[DATA_W-2:0], b};
    endfunction

    logic edge_hit, s_rise, s_fall, load_ok;
    logic [DATA_W-1:0] sh_next;

    always_comb begin
        edge_hit = busy_o && clk_run && (hc_q == HW'(HALF_CYC - 1));
        s_rise   = !is_master && !ss_s && sck_s && !sck_d_q;
        s_fall   = !is_master && !ss_s && !sck_s && sck_d_q;
        load_ok  = load && (is_master ? !busy_o : !s_run_q);
        sh_next  = shift_in(sh_q, rbit_q, lsb_first);
        tx_bit_o = lsb_first ? sh_q[0] : sh_q[DATA_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q      <= '0;
            rbit_q    <= 1'b0;
            hc_q      <= '0;
            ec_q      <= '0;
            sc_q      <= '0;
            s_run_q   <= 1'b0;
            sck_d_q   <= 1'b0;
            busy_o    <= 1'b0;
            sck_o     <= 1'b0;
            rx_data_o <= '0;
            done_o    <= 1'b0;
        end else begin
            sck_d_q <= sck_s;
            if (load_ok) begin
                sh_q   <= load_data;
                done_o <= 1'b0;
                if (is_master) begin
                    busy_o <= 1'b1;
                    hc_q   <= '0;
                    ec_q   <= '0;
                    sck_o  <= 1'b0;
                end
            end else if (!is_master) begin
                busy_o <= 1'b0;
                sck_o  <= 1'b0;
                if (ss_s) begin
                    sc_q    <= '0;
                    s_run_q <= 1'b0;
                end else if (s_rise) begin
                    rbit_q  <= din_s;
                    s_run_q <= 1'b1;
                end else if (s_fall && s_run_q) begin
                    sh_q <= sh_next;
                    if (sc_q == BW'(DATA_W - 1)) begin
                        sc_q      <= '0;
                        s_run_q   <= 1'b0;
                        done_o    <= 1'b1;
                        rx_data_o <= sh_next;
                    end else begin
                        sc_q <= sc_q + 1'b1;
                    end
                end
            end else begin
                sc_q    <= '0;
                s_run_q <= 1'b0;
                if (edge_hit) begin
                    hc_q <= '0;
                    ec_q <= ec_q + 1'b1;
                    if (!ec_q[0]) begin
                        sck_o  <= 1'b1;
                        rbit_q <= din_s;
                    end else begin
                        sck_o <= 1'b0;
                        sh_q  <= sh_next;
                        if (ec_q == EW'(NEDGE - 1)) begin
                            busy_o    <= 1'b0;
                            done_o    <= 1'b1;
                            rx_data_o <= sh_next;
                            ec_q      <= '0;
                        end
                    end
                end else if (busy_o && clk_run) begin
                    hc_q <= hc_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_port_ctl.sv
module spi_port_ctl
    import spi_port_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ss_dir_i,
    input  logic              wait_i,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe_o,
    input  logic              mosi_i,
    output logic              mosi_o,
    output logic              mosi_oe_o,
    input  logic              miso_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              ss_i,
    output logic              ss_o,
    output logic              ss_oe_o,
    output logic              ss_gp_o,
    output logic              xfer_done_o,
    output logic              mode_fault_o
);
    localparam int PAD_N = 4;
    localparam int PAD_SS = 2;
    localparam logic [PAD_N-1:0] PAD_RST = PAD_N'(1) << PAD_SS;

    spi_ctrl_t         ctrl_q;
    logic              fault_req;
    logic [PAD_N-1:0]  pad_s;
    logic              sck_s, ss_s, mosi_s, miso_s;
    logic              m_busy, tx_bit, din_s, clk_run, pin_drive;
    logic [DATA_W-1:0] rx_data;

    spi_sync2 #(.W(PAD_N), .RST_VAL(PAD_RST)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({sck_i, ss_i, mosi_i, miso_i}),
        .q   (pad_s)
    );
    assign {sck_s, ss_s, mosi_s, miso_s} = pad_s;

    spi_ctl_regs regs_i (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (reg_we && !reg_addr),
        .ctrl_wdata (spi_ctrl_t'(reg_wdata[CTRL_W-1:0])),
        .fault_req  (fault_req),
        .ctrl_q     (ctrl_q),
        .fault_q    (mode_fault_o)
    );

    spi_ss_sel ss_i_sel (
        .master    (ctrl_q.master),
        .ss_out_en (ctrl_q.ss_out_en),
        .ss_dir    (ss_dir_i),
        .ss_s      (ss_s),
        .m_busy    (m_busy),
        .fault_req (fault_req),
        .ss_o      (ss_o),
        .ss_oe     (ss_oe_o),
        .ss_gp     (ss_gp_o)
    );

    always_comb begin
        clk_run   = !(ctrl_q.stop_wait && wait_i);
        pin_drive = !ctrl_q.one_wire || ctrl_q.bidir_drive;
        if (ctrl_q.master) din_s = ctrl_q.one_wire ? mosi_s : miso_s;
        else               din_s = ctrl_q.one_wire ? miso_s : mosi_s;
    end

    spi_shift_eng #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) eng_i (
        .clk       (clk),
        .rst       (rst),
        .is_master (ctrl_q.master),
        .lsb_first (ctrl_q.lsb_first),
        .clk_run   (clk_run),
        .load      (reg_we && reg_addr),
        .load_data (reg_wdata),
        .sck_s     (sck_s),
        .ss_s      (ss_s),
        .din_s     (din_s),
        .busy_o    (m_busy),
        .sck_o     (sck_o),
        .tx_bit_o  (tx_bit),
        .rx_data_o (rx_data),
        .done_o    (xfer_done_o)
    );

    always_comb begin
        sck_oe_o  = ctrl_q.master;
        mosi_o    = tx_bit;
        mosi_oe_o = ctrl_q.master && pin_drive;
        miso_o    = tx_bit;
        miso_oe_o = !ctrl_q.master && !ss_s && pin_drive;
        reg_rdata = reg_addr ? rx_data : {{(DATA_W - CTRL_W){1'b0}}, ctrl_q};
    end
endmodule

// File: rtl/spi_port_ctl_chk.sv
module spi_port_ctl_chk (
    input logic clk,
    input logic rst,
    input logic master,
    input logic stop_wait,
    input logic wait_i,
    input logic sck_o,
    input logic sck_oe_o,
    input logic mosi_oe_o,
    input logic ss_o,
    input logic ss_oe_o,
    input logic ss_gp_o,
    input logic xfer_done_o,
    input logic mode_fault_o
);
    assert_fault_release_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_fault_o) |-> (!sck_oe_o && !mosi_oe_o));

    assert_slave_ss_input_R5: assert property (@(posedge clk) disable iff (rst)
        !sck_oe_o |-> (!ss_oe_o && !ss_gp_o));

    assert_ss_release_done_R7: assert property (@(posedge clk) disable iff (rst)
        (ss_oe_o && $rose(ss_o)) |-> xfer_done_o);

    assert_ss_low_not_done_R7: assert property (@(posedge clk) disable iff (rst)
        (ss_oe_o && !ss_o) |-> !xfer_done_o);

    assert_wait_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        $past(stop_wait && wait_i && master) |-> $stable(sck_o));

    assert_done_sck_idle_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(xfer_done_o) && sck_oe_o) |-> !sck_o);
endmodule

bind spi_port_ctl spi_port_ctl_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .master       (ctrl_q.master),
    .stop_wait    (ctrl_q.stop_wait),
    .wait_i       (wait_i),
    .sck_o        (sck_o),
    .sck_oe_o     (sck_oe_o),
    .mosi_oe_o    (mosi_oe_o),
    .ss_o         (ss_o),
    .ss_oe_o      (ss_oe_o),
    .ss_gp_o      (ss_gp_o),
    .xfer_done_o  (xfer_done_o),
    .mode_fault_o (mode_fault_o)
);

// File: tb/spi_port_ctl_tb_top.sv
module spi_port_ctl_tb_top;
    localparam int HALF = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic reg_we = 1'b0, reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic ss_dir = 1'b0, wait_in = 1'b0;
    logic tb_sck = 1'b0, tb_mosi = 1'b0, tb_miso = 1'b0, tb_ss = 1'b1;
    logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o, ss_oe, ss_gp, done, fault;
    logic sck_pad, mosi_pad, miso_pad, ss_pad;

    int checks = 0, errors = 0;
    bit cur_lsb = 0, cur_onew = 0;

    always #2 clk = ~clk;

    assign sck_pad  = sck_oe  ? sck_o  : tb_sck;
    assign mosi_pad = mosi_oe ? mosi_o : tb_mosi;
    assign miso_pad = miso_oe ? miso_o : tb_miso;
    assign ss_pad   = ss_oe   ? ss_o   : tb_ss;

    spi_port_ctl #(.DATA_W(8), .HALF_CYC(HALF)) dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ss_dir_i(ss_dir), .wait_i(wait_in),
        .sck_i(sck_pad), .sck_o(sck_o), .sck_oe_o(sck_oe),
        .mosi_i(mosi_pad), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe),
        .miso_i(miso_pad), .miso_o(miso_o), .miso_oe_o(miso_oe),
        .ss_i(ss_pad), .ss_o(ss_o), .ss_oe_o(ss_oe), .ss_gp_o(ss_gp),
        .xfer_done_o(done), .mode_fault_o(fault)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a; #0.5;
        d = reg_rdata;
    endtask

    function automatic logic [7:0] cfg(bit m, bit oe, bit lsb, bit sw, bit ow, bit dr);
        return {2'b00, dr, ow, sw, lsb, oe, m};
    endfunction

    function automatic logic bitsel(logic [7:0] v, int k);
        return cur_lsb ? v[k] : v[7-k];
    endfunction

    function automatic logic [7:0] put(logic [7:0] v, logic b);
        return cur_lsb ? {b, v[7:1]} : {v[6:0], b};
    endfunction

    task automatic set_line(input logic b);
        if (cur_onew) tb_mosi = b; else tb_miso = b;
    endtask

    task automatic m_xfer(input logic [7:0] tx, input logic [7:0] sb, input int wlen,
                          input bit stopw, input bit midwr, input bit chkcap,
                          input logic [7:0] exprx, input bit autoss, input string req);
        int k = 0;
        int got = 0;
        logic prev = 1'b0;
        logic [7:0] cap = '0;
        logic [7:0] d;
        int expc = 16 * HALF + (stopw ? wlen : 0);
        set_line(bitsel(sb, 0));
        wr(1'b1, tx);
        check({req, " done cleared by write"}, done, 0);
        if (autoss) check({req, " R7 select low at start"}, ss_pad, 0);
        for (int n = 1; n <= expc + 100 && got == 0; n++) begin
            if (n == 10 && wlen > 0) wait_in = 1'b1;
            if (n == 10 + wlen) wait_in = 1'b0;
            if (midwr && n == 20) begin reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = ~tx; end
            if (n == 21) reg_we = 1'b0;
            @(posedge clk); #1;
            if (sck_o && !prev) cap = put(cap, mosi_pad);
            if (!sck_o && prev) begin
                k++;
                if (k < 8) set_line(bitsel(sb, k));
            end
            prev = sck_o;
            if (done) got = n;
        end
        wait_in = 1'b0;
        check({req, " done cycle"}, got, expc);
        if (chkcap) check({req, " bits sent"}, cap, tx);
        rd(1'b1, d);
        check({req, " byte received"}, d, exprx);
        if (autoss) check({req, " R7 select high at done"}, ss_pad, 1);
        cyc(2);
    endtask

    task automatic s_xfer(input logic [7:0] ld, input logic [7:0] mb, input bit chkcap,
                          input logic [7:0] exprx, input string req);
        logic [7:0] cap = '0;
        logic [7:0] d;
        wr(1'b1, ld);
        check({req, " done cleared"}, done, 0);
        tb_ss = 1'b0; cyc(8);
        for (int k = 0; k < 8; k++) begin
            if (cur_onew) tb_miso = bitsel(mb, k); else tb_mosi = bitsel(mb, k);
            cyc(8);
            cap = put(cap, miso_pad);
            tb_sck = 1'b1; cyc(8);
            tb_sck = 1'b0;
        end
        cyc(6);
        check({req, " slave done"}, done, 1);
        if (chkcap) check({req, " slave bits sent"}, cap, ld);
        rd(1'b1, d);
        check({req, " slave byte received"}, d, exprx);
        tb_ss = 1'b1; cyc(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int seed;
        seed = $urandom(32'd2718);
        cyc(4); rst = 1'b0; cyc(1);

        // R1 reset state
        rd(1'b0, d); check("R1 ctrl", d, 0);
        rd(1'b1, d); check("R1 data", d, 0);
        check("R1 flags", {done, fault}, 0);
        check("R1 enables", {sck_oe, mosi_oe, miso_oe, ss_oe, ss_gp}, 0);
        cyc(1);

        // R4 master select roles
        for (int i = 0; i < 4; i++) begin
            ss_dir = i[1];
            wr(1'b0, cfg(1, i[0], 0, 0, 0, 0));
            cyc(1);
            check("R4 ss_oe", ss_oe, (i == 3));
            check("R4 ss_gp", ss_gp, (i == 1 || i == 2));
        end
        // R4 general-purpose input ignores a low pad
        ss_dir = 1'b0; wr(1'b0, cfg(1, 1, 0, 0, 0, 0));
        tb_ss = 1'b0; cyc(5);
        check("R4 no fault in gp input", fault, 0);
        check("R4 still master", sck_oe, 1);
        tb_ss = 1'b1; cyc(3);

        // R5 slave roles
        for (int i = 0; i < 4; i++) begin
            ss_dir = i[1];
            wr(1'b0, cfg(0, i[0], 0, 0, 0, 0));
            tb_ss = 1'b0; cyc(5);
            check("R5 slave ss pins", {ss_oe, ss_gp}, 0);
            check("R5 slave no fault", fault, 0);
            tb_ss = 1'b1; cyc(3);
        end

        // R6 mode fault
        ss_dir = 1'b0; wr(1'b0, cfg(1, 0, 0, 0, 0, 0)); cyc(1);
        check("R6 drivers before fault", {sck_oe, mosi_oe}, 2'b11);
        tb_ss = 1'b0; cyc(5);
        check("R6 fault flag", fault, 1);
        check("R6 drivers released", {sck_oe, mosi_oe}, 0);
        rd(1'b0, d); check("R6 master cleared", d, 0);
        tb_ss = 1'b1; cyc(3);
        wr(1'b0, cfg(0, 0, 0, 0, 0, 0));
        check("R6 flag cleared by ctrl write", fault, 0);

        // R2 R3 R7 directed master frames
        ss_dir = 1'b1;
        cur_lsb = 0; wr(1'b0, cfg(1, 1, 0, 0, 0, 0));
        m_xfer(8'hA5, 8'h3C, 0, 0, 0, 1, 8'h3C, 1, "R2 R3 msb");
        cur_lsb = 1; wr(1'b0, cfg(1, 1, 1, 0, 0, 0));
        m_xfer(8'h01, 8'h80, 0, 0, 0, 1, 8'h80, 1, "R3 lsb");
        m_xfer(8'hC4, 8'h5B, 0, 0, 0, 1, 8'h5B, 1, "R3 lsb second");

        // R8 wait handling
        cur_lsb = 0; wr(1'b0, cfg(1, 1, 0, 1, 0, 0));
        m_xfer(8'h96, 8'h69, 20, 1, 0, 1, 8'h69, 1, "R8 stop in wait");
        wr(1'b0, cfg(1, 1, 0, 0, 0, 0));
        m_xfer(8'h96, 8'h69, 20, 0, 0, 1, 8'h69, 1, "R8 run in wait");

        // R12 write during transfer
        m_xfer(8'h4E, 8'hD2, 0, 0, 1, 1, 8'hD2, 1, "R12 busy write");

        // R9 one-wire master
        cur_onew = 1;
        wr(1'b0, cfg(1, 1, 0, 0, 1, 1)); cyc(1);
        check("R9 mosi driven", mosi_oe, 1);
        m_xfer(8'h37, 8'h00, 0, 0, 0, 1, 8'h37, 1, "R9 drive loop");
        wr(1'b0, cfg(1, 1, 0, 0, 1, 0)); cyc(1);
        check("R9 mosi released", mosi_oe, 0);
        m_xfer(8'h11, 8'hE8, 0, 0, 0, 0, 8'hE8, 1, "R9 receive");

        // R10 one-wire slave
        wr(1'b0, cfg(0, 0, 0, 0, 1, 0));
        s_xfer(8'h5A, 8'hC3, 0, 8'hC3, "R10 receive");
        wr(1'b0, cfg(0, 0, 1, 0, 1, 1)); cur_lsb = 1;
        s_xfer(8'h2D, 8'h00, 1, 8'h2D, "R10 drive loop");
        cur_onew = 0;

        // R11 slave full duplex
        cur_lsb = 0; wr(1'b0, cfg(0, 0, 0, 0, 0, 0));
        s_xfer(8'hB1, 8'h4C, 1, 8'h4C, "R11 msb");
        cur_lsb = 1; wr(1'b0, cfg(0, 0, 1, 0, 0, 0));
        s_xfer(8'h0F, 8'hF2, 1, 8'hF2, "R11 lsb");

        // random master and slave frames
        for (int i = 0; i < 12; i++) begin
            logic [7:0] tx, sb;
            bit au;
            tx = 8'($urandom); sb = 8'($urandom); au = 1'($urandom);
            cur_lsb = 1'($urandom);
            ss_dir = au;
            wr(1'b0, cfg(1, au, cur_lsb, 0, 0, 0));
            m_xfer(tx, sb, 0, 0, 0, 1, sb, au, "R2 R3 random master");
        end
        for (int i = 0; i < 6; i++) begin
            logic [7:0] ld, mb;
            ld = 8'($urandom); mb = 8'($urandom);
            cur_lsb = 1'($urandom);
            wr(1'b0, cfg(0, 0, cur_lsb, 0, 0, 0));
            s_xfer(ld, mb, 1, mb, "R11 random slave");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule